// File: doc/BRIEF.md
# Reservation Station Array with Tag Broadcast

This block is the scheduling window in front of one class of functional unit. Instructions arrive in program order on an issue port with an opcode, two source register numbers, one destination register number and an immediate field. A register status table records, for every architectural register, either the tag of the station that will produce its next value or that the value in the local register file is current. A source that is current is copied into the station at issue. A source that is pending leaves only the producer's tag, and the station then watches the single result bus for that tag.

The destination of each issued instruction is renamed to the issuing station's tag. Name dependences (write-after-write, write-after-read) therefore never stall issue. Issue stalls only when every station is occupied. Each cycle, at most one station whose operands are all present is handed to the execution port, lowest index first. A result driven back onto the bus wakes every waiting station, updates the register file only when the register still names that producer, and frees the producing station.

Top module: `rs_array`

## Requirements
- R1: After reset no station is occupied, `issue_ready_o` is 1, `exec_valid_o` is 0, every register status reads tag 0, and register i holds the value i.
- R2: An accepted issue takes the lowest-index free station, whose tag is its index plus 1 (stations 0..3 carry tags 1..4). `issue_ready_o` is 0 exactly when all stations are occupied, and an issue offered while it is 0 changes nothing.
- R3: At issue, a source whose register status is 0 is copied from the register file. A source with a non-zero status records that tag and waits.
- R4: At issue, the destination's status becomes the new station's tag even when the register is already pending or is also a source of the same instruction. The sources read the state from before the rename.
- R5: When `res_valid_i` is 1, every occupied station holding `res_tag_i` in a source tag takes `res_data_i` into that operand and clears the tag at the same edge.
- R6: A station is presented on the execution port only while both source tags are 0, in the cycle after the edge at which it became ready, and exactly once.
- R7: When several stations are ready, the lowest index is presented first.
- R8: A result writes its register and clears the status only if that register's status equals `res_tag_i`. An older producer's result leaves both the register and the status unchanged.
- R9: The station whose tag is on the result bus becomes free at that edge.
- R10: If a source's producer broadcasts in the same cycle as the issue, the broadcast value is taken directly and the source does not wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request |
| issue_op_i | input | OP_W | Opcode |
| issue_src1_i | input | REG_AW | First source register |
| issue_src2_i | input | REG_AW | Second source register |
| issue_dst_i | input | REG_AW | Destination register |
| issue_imm_i | input | DATA_W | Address or immediate field |
| issue_ready_o | output | 1 | A station is free |
| exec_valid_o | output | 1 | Ready station presented for execution |
| exec_tag_o | output | TAG_W | Tag of the presented station |
| exec_op_o | output | OP_W | Its opcode |
| exec_vj_o | output | DATA_W | First operand |
| exec_vk_o | output | DATA_W | Second operand |
| exec_imm_o | output | DATA_W | Its immediate |
| res_valid_i | input | 1 | Result bus valid |
| res_tag_i | input | TAG_W | Tag of the producing station |
| res_data_i | input | DATA_W | Result value |
| rd_addr_i | input | REG_AW | Register file read address |
| rd_data_o | output | DATA_W | Register value |
| rd_tag_o | output | TAG_W | Register status (0 means current) |

## Verification
An issue or broadcast is applied across one rising edge. The station state, the register status and the register file are then updated, so the status and read port show the effect at the following falling edge. A station that is ready after that edge appears on the execution port in the same half cycle. It disappears one edge later, because presenting it marks it as started. The bench drives inputs just after a falling edge and checks at the next falling edge. It moves the read address and waits one time unit before comparing. This puts every check in the single cycle where the requirement places the result, and it catches an extra register stage or a missing bypass as a wrong value.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int unsigned DEF_NUM_RS   = 4;
  localparam int unsigned DEF_NUM_REGS = 8;
  localparam int unsigned DEF_DATA_W   = 16;
  localparam int unsigned DEF_OP_W     = 3;
endpackage

// File: rtl/rs_select.sv
module rs_select #(
  parameter int unsigned N     = 4,
  localparam int unsigned IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/rs_reg_status.sv
module rs_reg_status #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned TAG_W    = 3,
  localparam int unsigned AW      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ren_we_i,
  input  logic [AW-1:0]     ren_dst_i,
  input  logic [TAG_W-1:0]  ren_tag_i,
  input  logic [AW-1:0]     src1_i,
  input  logic [AW-1:0]     src2_i,
  output logic [TAG_W-1:0]  src1_tag_o,
  output logic [DATA_W-1:0] src1_val_o,
  output logic [TAG_W-1:0]  src2_tag_o,
  output logic [DATA_W-1:0] src2_val_o,
  input  logic              res_valid_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [TAG_W-1:0]  rd_tag_o
);
  logic [DATA_W-1:0] val_q [NUM_REGS];
  logic [TAG_W-1:0]  tag_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic hit;
    logic ren;
    assign hit = res_valid_i && (res_tag_i != '0) && (tag_q[r] == res_tag_i);
    assign ren = ren_we_i && (ren_dst_i == AW'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q[r] <= DATA_W'(r);
        tag_q[r] <= '0;
      end else begin
        if (hit) val_q[r] <= res_data_i;
        if (ren)      tag_q[r] <= ren_tag_i;  // newest writer wins
        else if (hit) tag_q[r] <= '0;
      end
    end
  end

  assign src1_tag_o = tag_q[src1_i];
  assign src1_val_o = val_q[src1_i];
  assign src2_tag_o = tag_q[src2_i];
  assign src2_val_o = val_q[src2_i];
  assign rd_data_o  = val_q[rd_addr_i];
  assign rd_tag_o   = tag_q[rd_addr_i];
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned OP_W   = 3,
  parameter int unsigned TAG_W  = 3,
  parameter logic [TAG_W-1:0] OWN_TAG = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic [TAG_W-1:0]  qj_i,
  input  logic [DATA_W-1:0] vj_i,
  input  logic [TAG_W-1:0]  qk_i,
  input  logic [DATA_W-1:0] vk_i,
  input  logic              grant_i,
  input  logic              res_valid_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic [DATA_W-1:0] res_data_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] vj_o,
  output logic [DATA_W-1:0] vk_o,
  output logic [DATA_W-1:0] imm_o
);
  logic              busy_q, started_q;
  logic [TAG_W-1:0]  qj_q, qk_q;
  logic [DATA_W-1:0] vj_q, vk_q, imm_q;
  logic [OP_W-1:0]   op_q;
  logic              wake_j, wake_k, done;

  assign wake_j = busy_q && res_valid_i && (qj_q != '0) && (qj_q == res_tag_i);
  assign wake_k = busy_q && res_valid_i && (qk_q != '0) && (qk_q == res_tag_i);
  assign done   = busy_q && res_valid_i && (res_tag_i == OWN_TAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; started_q <= 1'b0;
      qj_q <= '0; qk_q <= '0; vj_q <= '0; vk_q <= '0;
      imm_q <= '0; op_q <= '0;
    end else if (alloc_i) begin
      busy_q <= 1'b1; started_q <= 1'b0;
      op_q <= op_i; imm_q <= imm_i;
      qj_q <= qj_i; vj_q <= vj_i;
      qk_q <= qk_i; vk_q <= vk_i;
    end else begin
      if (done)    busy_q <= 1'b0;
      if (grant_i) started_q <= 1'b1;
      if (wake_j) begin vj_q <= res_data_i; qj_q <= '0; end
      if (wake_k) begin vk_q <= res_data_i; qk_q <= '0; end
    end
  end

  assign busy_o  = busy_q;
  assign ready_o = busy_q && !started_q && (qj_q == '0) && (qk_q == '0);
  assign op_o    = op_q;
  assign vj_o    = vj_q;
  assign vk_o    = vk_q;
  assign imm_o   = imm_q;
endmodule

// File: rtl/rs_array.sv
module rs_array
  import rs_pkg::*;
#(
  parameter int unsigned NUM_RS   = DEF_NUM_RS,
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned OP_W     = DEF_OP_W,
  localparam int unsigned REG_AW  = $clog2(NUM_REGS),
  localparam int unsigned TAG_W   = $clog2(NUM_RS + 1),
  localparam int unsigned IDX_W   = (NUM_RS > 1) ? $clog2(NUM_RS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [OP_W-1:0]   issue_op_i,
  input  logic [REG_AW-1:0] issue_src1_i,
  input  logic [REG_AW-1:0] issue_src2_i,
  input  logic [REG_AW-1:0] issue_dst_i,
  input  logic [DATA_W-1:0] issue_imm_i,
  output logic              issue_ready_o,
  output logic              exec_valid_o,
  output logic [TAG_W-1:0]  exec_tag_o,
  output logic [OP_W-1:0]   exec_op_o,
  output logic [DATA_W-1:0] exec_vj_o,
  output logic [DATA_W-1:0] exec_vk_o,
  output logic [DATA_W-1:0] exec_imm_o,
  input  logic              res_valid_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic [DATA_W-1:0] res_data_i,
  input  logic [REG_AW-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [TAG_W-1:0]  rd_tag_o
);
  logic [NUM_RS-1:0] busy, ready, free, grant, alloc;
  logic              free_any, ready_any, issue_fire;
  logic [IDX_W-1:0]  free_idx, ready_idx;
  logic [TAG_W-1:0]  alloc_tag;
  logic [TAG_W-1:0]  s1_tag, s2_tag, qj, qk;
  logic [DATA_W-1:0] s1_val, s2_val, vj, vk;
  logic [OP_W-1:0]   e_op  [NUM_RS];
  logic [DATA_W-1:0] e_vj  [NUM_RS];
  logic [DATA_W-1:0] e_vk  [NUM_RS];
  logic [DATA_W-1:0] e_imm [NUM_RS];

  assign free = ~busy;

  rs_select #(.N(NUM_RS)) u_free_sel (.req_i(free),  .any_o(free_any),  .idx_o(free_idx));
  rs_select #(.N(NUM_RS)) u_rdy_sel  (.req_i(ready), .any_o(ready_any), .idx_o(ready_idx));

  assign issue_ready_o = free_any;
  assign issue_fire    = issue_valid_i && free_any;
  assign alloc_tag     = TAG_W'(free_idx) + TAG_W'(1);

  rs_reg_status #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_status (
    .clk_i, .rst_ni,
    .ren_we_i(issue_fire), .ren_dst_i(issue_dst_i), .ren_tag_i(alloc_tag),
    .src1_i(issue_src1_i), .src2_i(issue_src2_i),
    .src1_tag_o(s1_tag), .src1_val_o(s1_val),
    .src2_tag_o(s2_tag), .src2_val_o(s2_val),
    .res_valid_i, .res_tag_i, .res_data_i,
    .rd_addr_i, .rd_data_o, .rd_tag_o
  );

  // same-cycle broadcast bypass into the issuing entry
  always_comb begin
    qj = s1_tag; vj = s1_val;
    qk = s2_tag; vk = s2_val;
    if (res_valid_i && s1_tag != '0 && s1_tag == res_tag_i) begin qj = '0; vj = res_data_i; end
    if (res_valid_i && s2_tag != '0 && s2_tag == res_tag_i) begin qk = '0; vk = res_data_i; end
  end

  for (genvar s = 0; s < NUM_RS; s++) begin : g_rs
    assign alloc[s] = issue_fire && (free_idx == IDX_W'(s));
    assign grant[s] = ready_any && (ready_idx == IDX_W'(s));
    rs_entry #(.DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W),
               .OWN_TAG(TAG_W'(s + 1))) u_entry (
      .clk_i, .rst_ni,
      .alloc_i(alloc[s]), .op_i(issue_op_i), .imm_i(issue_imm_i),
      .qj_i(qj), .vj_i(vj), .qk_i(qk), .vk_i(vk),
      .grant_i(grant[s]),
      .res_valid_i, .res_tag_i, .res_data_i,
      .busy_o(busy[s]), .ready_o(ready[s]),
      .op_o(e_op[s]), .vj_o(e_vj[s]), .vk_o(e_vk[s]), .imm_o(e_imm[s])
    );
  end

  assign exec_valid_o = ready_any;
  assign exec_tag_o   = TAG_W'(ready_idx) + TAG_W'(1);
  assign exec_op_o    = e_op[ready_idx];
  assign exec_vj_o    = e_vj[ready_idx];
  assign exec_vk_o    = e_vk[ready_idx];
  assign exec_imm_o   = e_imm[ready_idx];
endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk #(
  parameter int unsigned NUM_RS = 4,
  parameter int unsigned TAG_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_RS-1:0] busy_i,
  input logic              issue_valid_i,
  input logic              issue_ready_i,
  input logic              exec_valid_i,
  input logic [TAG_W-1:0]  exec_tag_i,
  input logic              res_valid_i,
  input logic [TAG_W-1:0]  res_tag_i
);
  // R2: an issue refused while full leaves occupancy alone
  assert_full_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_i && !issue_ready_i && !res_valid_i |=> $stable(busy_i));

  // R6: presented tag always names an occupied station
  assert_exec_busy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid_i |-> (exec_tag_i != '0) && (exec_tag_i <= TAG_W'(NUM_RS))
                     && busy_i[exec_tag_i - TAG_W'(1)]);

  // R6: a station is not presented twice in a row
  assert_exec_once_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid_i |=> !(exec_valid_i && exec_tag_i == $past(exec_tag_i)));

  // R9: the broadcasting station is free after the edge
  assert_free_on_result_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && res_tag_i != '0 && res_tag_i <= TAG_W'(NUM_RS)
    |=> !busy_i[$past(res_tag_i) - TAG_W'(1)]);

  // R2: ready flag tracks occupancy
  assert_ready_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_ready_i == (busy_i != '1));
endmodule

bind rs_array rs_array_chk #(.NUM_RS(NUM_RS), .TAG_W(TAG_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy),
  .issue_valid_i(issue_valid_i), .issue_ready_i(issue_ready_o),
  .exec_valid_i(exec_valid_o), .exec_tag_i(exec_tag_o),
  .res_valid_i(res_valid_i), .res_tag_i(res_tag_i)
);

// File: tb/tb_rs_array.sv
module tb_rs_array;
  localparam int CLK_PERIOD = 10;
  localparam int NRS = 4, NREG = 8, DW = 16, OW = 3;
  localparam int AW = 3, TW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic issue_valid_i = 0;
  logic [OW-1:0] issue_op_i = '0;
  logic [AW-1:0] issue_src1_i = '0, issue_src2_i = '0, issue_dst_i = '0;
  logic [DW-1:0] issue_imm_i = '0;
  logic issue_ready_o, exec_valid_o;
  logic [TW-1:0] exec_tag_o;
  logic [OW-1:0] exec_op_o;
  logic [DW-1:0] exec_vj_o, exec_vk_o, exec_imm_o;
  logic res_valid_i = 0;
  logic [TW-1:0] res_tag_i = '0;
  logic [DW-1:0] res_data_i = '0;
  logic [AW-1:0] rd_addr_i = '0;
  logic [DW-1:0] rd_data_o;
  logic [TW-1:0] rd_tag_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] mreg [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_array #(.NUM_RS(NRS), .NUM_REGS(NREG), .DATA_W(DW), .OP_W(OW)) dut (.clk_i(clk), .*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic issue(int op, int s1, int s2, int d, int imm);
    issue_valid_i = 1; issue_op_i = OW'(op); issue_src1_i = AW'(s1);
    issue_src2_i = AW'(s2); issue_dst_i = AW'(d); issue_imm_i = DW'(imm);
    tick();
    issue_valid_i = 0;
  endtask

  task automatic bcast(int tag, int data);
    res_valid_i = 1; res_tag_i = TW'(tag); res_data_i = DW'(data);
    tick();
    res_valid_i = 0;
  endtask

  task automatic rd_chk(string req, int a, int exp_data, int exp_tag);
    rd_addr_i = AW'(a); #1;
    chk(req, 32'(rd_data_o), 32'(DW'(exp_data)));
    chk(req, 32'(rd_tag_o), 32'(exp_tag));
  endtask

  task automatic ex_chk(string req, int tag, int vj, int vk);
    chk(req, 32'(exec_valid_o), 1);
    chk(req, 32'(exec_tag_o), 32'(tag));
    chk(req, 32'(exec_vj_o), 32'(DW'(vj)));
    chk(req, 32'(exec_vk_o), 32'(DW'(vk)));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NREG; i++) mreg[i] = DW'(i);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ready", 32'(issue_ready_o), 1);
    chk("R1 exec", 32'(exec_valid_o), 0);
    for (int i = 0; i < NREG; i++) rd_chk("R1 regs", i, i, 0);
    rst_ni = 1;
    @(negedge clk);

    // R3/R6: ready operands dispatch next cycle
    issue(1, 2, 3, 4, 9);
    ex_chk("R3 R6 ready sources", 1, 2, 3);
    chk("R6 op", 32'(exec_op_o), 1);
    chk("R6 imm", 32'(exec_imm_o), 9);
    rd_chk("R4 rename", 4, 4, 1);
    // R3: pending source waits
    issue(2, 4, 5, 6, 0);
    chk("R3 R6 waits on tag", 32'(exec_valid_o), 0);
    // R5/R8/R9: wake on broadcast
    bcast(1, 16'h55); mreg[4] = 16'h55;
    ex_chk("R5 wake", 2, 16'h55, 5);
    rd_chk("R8 write", 4, 16'h55, 0);

    // R4/R8: WAW, only newest writer updates
    issue(3, 0, 0, 7, 0);
    chk("R2 R9 reuse freed station", 32'(exec_tag_o), 1);
    issue(4, 1, 1, 7, 0);
    chk("R2 lowest free", 32'(exec_tag_o), 3);
    rd_chk("R4 newest tag", 7, 7, 3);
    bcast(1, 16'hAAAA);
    chk("R6 once", 32'(exec_valid_o), 0);
    rd_chk("R8 stale result ignored", 7, 7, 3);
    bcast(3, 16'h1234); mreg[7] = 16'h1234;
    rd_chk("R8 newest result", 7, 16'h1234, 0);
    bcast(2, 16'h6666); mreg[6] = 16'h6666;
    rd_chk("R8 reg6", 6, 16'h6666, 0);

    // R10: issue during producer broadcast
    issue(5, 1, 1, 5, 0);
    ex_chk("R3 st1", 1, 1, 1);
    issue_valid_i = 1; issue_op_i = 3'd6; issue_src1_i = 3'd5;
    issue_src2_i = 3'd2; issue_dst_i = 3'd0; issue_imm_i = '0;
    res_valid_i = 1; res_tag_i = 3'd1; res_data_i = 16'h0F0F;
    tick();
    issue_valid_i = 0; res_valid_i = 0; mreg[5] = 16'h0F0F;
    ex_chk("R10 same-cycle capture", 2, 16'h0F0F, 2);
    rd_chk("R8 reg5", 5, 16'h0F0F, 0);
    bcast(2, 16'h00AB); mreg[0] = 16'h00AB;

    // R7: two woken together, lowest first
    issue(0, 0, 0, 1, 0);
    issue(1, 1, 2, 2, 0);
    issue(1, 1, 3, 3, 0);
    chk("R6 none ready", 32'(exec_valid_o), 0);
    bcast(1, 16'h0101); mreg[1] = 16'h0101;
    ex_chk("R7 first", 2, 16'h0101, 2);
    tick();
    ex_chk("R7 second", 3, 16'h0101, 3);
    tick();
    chk("R7 drained", 32'(exec_valid_o), 0);
    bcast(2, 16'h0202); mreg[2] = 16'h0202;
    bcast(3, 16'h0303); mreg[3] = 16'h0303;

    // R2: full array
    for (int k = 0; k < NRS; k++) issue(k, 4, 4, k, 0);
    chk("R2 full", 32'(issue_ready_o), 0);
    tick();
    chk("R6 all presented", 32'(exec_valid_o), 0);
    issue(7, 0, 0, 6, 0);
    rd_chk("R2 ignored issue", 6, 16'h6666, 0);
    chk("R2 still full", 32'(issue_ready_o), 0);
    chk("R2 no new entry", 32'(exec_valid_o), 0);
    bcast(1, 16'h1001); mreg[0] = 16'h1001;
    chk("R9 freed", 32'(issue_ready_o), 1);
    for (int k = 2; k <= NRS; k++) begin
      bcast(k, 16'h1000 + k); mreg[k-1] = DW'(16'h1000 + k);
    end

    // R3/R4 sweep over every register, source also destination (WAR)
    for (int r = 0; r < NREG; r++) begin
      issue(r, r, NREG-1-r, r, r);
      ex_chk("R3 R4 sweep", 1, int'(mreg[r]), int'(mreg[NREG-1-r]));
      chk("R6 sweep imm", 32'(exec_imm_o), 32'(r));
      bcast(1, r*17 + 1); mreg[r] = DW'(r*17 + 1);
    end
    for (int r = 0; r < NREG; r++) rd_chk("R8 final regs", r, int'(mreg[r]), 0);
    finish_run();
  end
endmodule